// File: doc/BRIEF.md
# Critical-Conduction PFC Cycle Controller

This block is the timing core of a boost power-factor-correction stage that runs in critical conduction. It decides when the boost switch turns on and how long it stays on. The analog parts of the loop sit outside the block. Comparators deliver the zero-current-detect thresholds, the overcurrent limit and the overvoltage limit as single-bit flags. The error amplifier delivers its output as an unsigned control word.

A switching cycle begins when the inductor has demagnetised. The block sees this as the sense winding first rising above its high threshold (which arms it) and then falling below its low threshold (which triggers it). If no cycle has started for a programmable time, a restart timer begins one instead. This covers start-up and very light load.

The on time is constant for a given control word. A counter runs while the drive is high. The pulse ends at the first of these events: the counter plus a fixed offset reaches the control word, the counter reaches its ceiling, or the overcurrent flag is seen after the blanking window. Because of the offset, a low control word gives zero duty. The switching cycle is free-running and has no relation to any other oscillator in the system.

Top module: `pfc_crm_ctrl`

## Requirements
- R1: While reset is asserted, and on every cycle after a cycle in which `enable` is low, `pdrv` and `first_pulse` are 0.
- R2: A low-threshold indication (`zcd_lo_flag`=1) that is not preceded by a high-threshold indication (`zcd_hi_flag`=1) seen while `pdrv` was low starts no pulse.
- R3: When the detector is armed, `pdrv` is low, `enable`=1, `ovp_flag`=0 and `ctrl_word` > OFFSET, a cycle with `zcd_lo_flag`=1 raises `pdrv` at the next clock edge.
- R4: Arming is cleared when a pulse starts. `zcd_hi_flag` seen while `pdrv` is high does not arm, so after that pulse a held `zcd_lo_flag` starts no new one.
- R5: With no other limit active, `pdrv` stays high for exactly `ctrl_word` - OFFSET cycles.
- R6: When `ctrl_word` <= OFFSET, `pdrv` is low on the next cycle and no pulse starts from either the detector or the timer (zero duty).
- R7: A pulse never lasts more than RAMP_MAX cycles, and it lasts exactly RAMP_MAX cycles when `ctrl_word` - OFFSET >= RAMP_MAX.
- R8: `ocp_flag` has no effect during the first BLANK_CYC cycles of a pulse. After that, an asserted `ocp_flag` makes `pdrv` low at the next edge.
- R9: When no pulse has started for WDOG_CYC cycles, a pulse starts. With no detector events, rising edges of `pdrv` are exactly WDOG_CYC cycles apart.
- R10: While `ovp_flag`=1, no pulse starts, and a running pulse ends at the next edge. A restart that fell due during overvoltage happens at the first edge after the flag clears.
- R11: `first_pulse` rises at the same edge as the first rise of `pdrv` after `enable` goes high. It then stays high while `enable` stays high.
- R12: Dropping `enable` ends a running pulse at the next edge and discards any arming. After re-enable, a low-threshold indication alone starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller run permission (low acts as undervoltage fault) |
| ctrl_word | input | CTRL_W | Error-amplifier output as unsigned on-time target, compared with counter + OFFSET |
| zcd_hi_flag | input | 1 | Sense winding above the arming threshold |
| zcd_lo_flag | input | 1 | Sense winding below the trigger threshold |
| ocp_flag | input | 1 | Switch current above the limit |
| ovp_flag | input | 1 | Output voltage above the overvoltage limit |
| pdrv | output | 1 | Boost switch drive |
| first_pulse | output | 1 | Sticky flag: a pulse has been issued since enable |

## Verification
All outputs are registered. A triggering input sampled at one edge shows on `pdrv` at that same edge, so the result is visible at the following falling edge. A terminating condition seen during the last high cycle drops `pdrv` one edge later. The bench drives its inputs on falling edges. A behavioural model advances on each rising edge, and both outputs are compared with it at every falling edge. Directed checks measure pulse widths and restart periods by counting falling edges with `pdrv` high. They sample the single-edge responses (trigger, overvoltage abort, enable drop) at the first falling edge after the stimulus edge.

// File: rtl/pfc_crm_pkg.sv
// Shared types for the critical-conduction PFC cycle controller.
// Assumes nothing beyond a single clock domain.
package pfc_crm_pkg;

    // State of the zero-current detector: waiting for the rise, or armed.
    typedef enum logic {
        ZCD_IDLE  = 1'b0,
        ZCD_ARMED = 1'b1
    } zcd_state_t;

endpackage

// File: rtl/pfc_zcd_arm.sv
// Zero-current detector sequencer.
// Arms on a high-threshold indication seen while the switch is off and fires
// when the low-threshold indication arrives while armed. Arming is dropped at
// every pulse start and whenever the controller is disabled.
// Assumes the threshold flags are already synchronous to clk.
module pfc_zcd_arm
    import pfc_crm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pdrv,
    input  logic start,
    input  logic zcd_hi,
    input  logic zcd_lo,
    output logic trig
);

    zcd_state_t state_q;

    // Arm/disarm sequencing of the detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZCD_IDLE;
        end else if (!enable || start) begin
            state_q <= ZCD_IDLE;
        end else if (zcd_hi && !pdrv) begin
            state_q <= ZCD_ARMED;
        end
    end

    // Trigger request: armed and the winding has collapsed.
    assign trig = (state_q == ZCD_ARMED) && zcd_lo;

endmodule

// File: rtl/pfc_restart_timer.sv
// Restart timer for the switching cycle.
// Counts cycles since the last pulse start and flags expiry after WDOG_CYC
// cycles. It saturates when expired, so a restart that is blocked stays
// pending. It is cleared by a pulse start or by disable.
// Assumes WDOG_CYC >= 2.
module pfc_restart_timer #(
    parameter int WDOG_CYC = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    output logic expire
);

    localparam int WD_W = $clog2(WDOG_CYC);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYC - 1);

    logic [WD_W-1:0] cnt_q;

    // Elapsed-time counter with saturation at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || start) begin
            cnt_q <= '0;
        end else if (cnt_q != WD_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry indication.
    assign expire = (cnt_q == WD_LAST);

endmodule

// File: rtl/pfc_ontime.sv
// On-time generator.
// Raises the drive on a start request and counts the cycles while it is high.
// It ends the pulse when counter + OFFSET reaches the control word, when the
// counter reaches RAMP_MAX, when overcurrent is seen after BLANK_CYC cycles,
// or on overvoltage or disable. The counter is zero whenever the drive is low.
// Assumes BLANK_CYC < RAMP_MAX and RAMP_MAX >= 2.
module pfc_ontime #(
    parameter int CTRL_W    = 14,
    parameter int OFFSET    = 400,
    parameter int RAMP_MAX  = 5000,
    parameter int BLANK_CYC = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              ocp_flag,
    input  logic              ovp_flag,
    output logic              pdrv,
    output logic              can_fire
);

    localparam int RW    = $clog2(RAMP_MAX + 1);
    localparam int SUM_W = ((CTRL_W > RW) ? CTRL_W : RW) + 2;
    localparam logic [SUM_W-1:0] OFF_S     = SUM_W'(OFFSET);
    localparam logic [SUM_W-1:0] ONE_S     = SUM_W'(1);
    localparam logic [RW-1:0]    PEAK_LAST = RW'(RAMP_MAX - 1);

    logic [RW-1:0]    ramp_q;
    logic             pdrv_q;
    logic [SUM_W-1:0] ramp_s;
    logic [SUM_W-1:0] ctrl_s;
    logic             hit_ctrl;
    logic             hit_peak;
    logic             blank_done;
    logic             ocp_live;
    logic             abort;
    logic             stop;

    assign ramp_s = SUM_W'(ramp_q);
    assign ctrl_s = SUM_W'(ctrl_word);

    // Control-word window: ramp plus offset reaching the target.
    assign hit_ctrl = (ramp_s + OFF_S + ONE_S) >= ctrl_s;
    assign hit_peak = (ramp_q >= PEAK_LAST);
    assign can_fire = (ctrl_s > OFF_S);

    // Leading-edge blanking: a zero window needs no comparator.
    generate
        if (BLANK_CYC == 0) begin : g_no_blank
            assign blank_done = 1'b1;
        end else begin : g_blank
            localparam logic [RW-1:0] BLANK_END = RW'(BLANK_CYC);
            assign blank_done = (ramp_q >= BLANK_END);
        end
    endgenerate

    assign ocp_live = ocp_flag && blank_done;
    assign abort    = !enable || ovp_flag;
    assign stop     = pdrv_q && (abort || hit_ctrl || hit_peak || ocp_live);

    // Drive flop: set on start, held until a terminating condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdrv_q <= 1'b0;
        end else if (start) begin
            pdrv_q <= 1'b1;
        end else if (stop) begin
            pdrv_q <= 1'b0;
        end
    end

    // On-time counter: runs only across the high phase of the drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_q <= '0;
        end else if (pdrv_q && !stop) begin
            ramp_q <= ramp_q + 1'b1;
        end else begin
            ramp_q <= '0;
        end
    end

    assign pdrv = pdrv_q;

endmodule

// File: rtl/pfc_crm_ctrl.sv
// Critical-conduction PFC cycle controller (top).
// Combines the detector sequencer, the restart timer and the on-time
// generator. A pulse starts when the controller is enabled, the switch is
// off, overvoltage is clear, the control word is above the offset, and either
// the detector fires or the timer has expired. Also keeps a sticky
// first-pulse flag that is cleared by disable.
// Assumes all inputs are synchronous to clk.
module pfc_crm_ctrl #(
    parameter int CTRL_W    = 14,
    parameter int OFFSET    = 400,
    parameter int RAMP_MAX  = 5000,
    parameter int BLANK_CYC = 22,
    parameter int WDOG_CYC  = 36000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              zcd_hi_flag,
    input  logic              zcd_lo_flag,
    input  logic              ocp_flag,
    input  logic              ovp_flag,
    output logic              pdrv,
    output logic              first_pulse
);

    logic trig;
    logic expire;
    logic can_fire;
    logic start;
    logic first_q;

    // Start request shared by all three sub-blocks.
    assign start = enable && !pdrv && !ovp_flag && can_fire && (trig || expire);

    pfc_zcd_arm u_zcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .pdrv   (pdrv),
        .start  (start),
        .zcd_hi (zcd_hi_flag),
        .zcd_lo (zcd_lo_flag),
        .trig   (trig)
    );

    pfc_restart_timer #(
        .WDOG_CYC (WDOG_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (start),
        .expire (expire)
    );

    pfc_ontime #(
        .CTRL_W    (CTRL_W),
        .OFFSET    (OFFSET),
        .RAMP_MAX  (RAMP_MAX),
        .BLANK_CYC (BLANK_CYC)
    ) u_ontime (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .ctrl_word (ctrl_word),
        .ocp_flag  (ocp_flag),
        .ovp_flag  (ovp_flag),
        .pdrv      (pdrv),
        .can_fire  (can_fire)
    );

    // Sticky first-pulse flag, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (!enable) begin
            first_q <= 1'b0;
        end else if (start) begin
            first_q <= 1'b1;
        end
    end

    assign first_pulse = first_q;

endmodule

// File: rtl/pfc_crm_chk.sv
// Property checker for the PFC cycle controller, observing ports only.
// Keeps its own count of consecutive high drive cycles to check time windows.
module pfc_crm_chk #(
    parameter int CTRL_W    = 14,
    parameter int OFFSET    = 400,
    parameter int RAMP_MAX  = 5000,
    parameter int BLANK_CYC = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              ocp_flag,
    input logic              ovp_flag,
    input logic              pdrv,
    input logic              first_pulse
);

    int unsigned hi_len;

    // Number of high drive cycles that came before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= 0;
        end else if (pdrv) begin
            hi_len <= hi_len + 1;
        end else begin
            hi_len <= 0;
        end
    end

    p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pdrv && !first_pulse));

    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ctrl_word) <= OFFSET) |=> !pdrv);

    p_peak_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pdrv |-> (hi_len < RAMP_MAX));

    p_blanking_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pdrv && enable && !ovp_flag && (hi_len < BLANK_CYC)
         && (int'(ctrl_word) > OFFSET + int'(hi_len) + 1)
         && (hi_len + 1 < RAMP_MAX)) |=> pdrv);

    p_ovp_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_flag |=> !pdrv);

    p_first_with_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdrv) |-> first_pulse);

    p_first_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && first_pulse) |=> first_pulse);

    p_no_ocp_effect_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pdrv && $past(pdrv) && ocp_flag && (hi_len < BLANK_CYC) && enable && !ovp_flag
         && (int'(ctrl_word) > OFFSET + int'(hi_len) + 1)
         && (hi_len + 1 < RAMP_MAX)) |=> pdrv);

endmodule

bind pfc_crm_ctrl pfc_crm_chk #(
    .CTRL_W    (CTRL_W),
    .OFFSET    (OFFSET),
    .RAMP_MAX  (RAMP_MAX),
    .BLANK_CYC (BLANK_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ctrl_word   (ctrl_word),
    .ocp_flag    (ocp_flag),
    .ovp_flag    (ovp_flag),
    .pdrv        (pdrv),
    .first_pulse (first_pulse)
);

// File: tb/pfc_crm_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for the PFC cycle controller: behavioural model compared every clock,
// plus directed width, period and response checks.
module pfc_crm_ctrl_tb_top;

    localparam int CW   = 8;
    localparam int OFF  = 20;
    localparam int RMAX = 60;
    localparam int BLK  = 4;
    localparam int WD   = 150;
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic          hi = 1'b0;
    logic          lo = 1'b0;
    logic          ocp = 1'b0;
    logic          ovp = 1'b0;
    logic          pdrv;
    logic          first_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // Model state.
    bit m_pdrv = 0;
    int m_ramp = 0;
    bit m_armed = 0;
    int m_wd = 0;
    bit m_first = 0;

    always #2.5 clk = ~clk;

    pfc_crm_ctrl #(
        .CTRL_W(CW), .OFFSET(OFF), .RAMP_MAX(RMAX), .BLANK_CYC(BLK), .WDOG_CYC(WD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(en), .ctrl_word(ctrl),
        .zcd_hi_flag(hi), .zcd_lo_flag(lo), .ocp_flag(ocp), .ovp_flag(ovp),
        .pdrv(pdrv), .first_pulse(first_pulse)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit go, end_now, fire;
        if (!rst_n) begin
            m_pdrv = 0; m_ramp = 0; m_armed = 0; m_wd = 0; m_first = 0;
        end else begin
            fire = (m_armed && lo) || (m_wd >= WD - 1);
            go = en && !m_pdrv && !ovp && (int'(ctrl) > OFF) && fire;
            end_now = m_pdrv && (!en || ovp || (m_ramp + 1 + OFF >= int'(ctrl))
                      || (m_ramp + 1 >= RMAX) || (ocp && m_ramp >= BLK));
            if (!en || go) m_armed = 0;
            else if (hi && !m_pdrv) m_armed = 1;
            if (!en || go) m_wd = 0;
            else if (m_wd < WD - 1) m_wd++;
            if (!en) m_first = 0;
            else if (go) m_first = 1;
            if (go) begin
                m_pdrv = 1; m_ramp = 0;
            end else if (end_now) begin
                m_pdrv = 0; m_ramp = 0;
            end else if (m_pdrv) begin
                m_ramp++;
            end
        end
    end

    // Compare with the model at every falling edge; run the watchdog.
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            check(pdrv === m_pdrv, {cur_req, " pdrv vs model"}, int'(pdrv), int'(m_pdrv));
            check(first_pulse === m_first, {cur_req, " first_pulse vs model"},
                  int'(first_pulse), int'(m_first));
            if (cyc > LIMIT) begin
                done = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
                summary();
                $finish;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Arm then trigger; returns at the falling edge after the start edge.
    task automatic do_trigger();
        hi = 1'b1; lo = 1'b0;
        step(1);
        hi = 1'b0; lo = 1'b1;
        step(1);
    endtask

    // Counts falling edges with pdrv high, starting at the current one.
    task automatic measure_high(output int w);
        w = 0;
        while (pdrv === 1'b1 && w < 1000) begin
            w++;
            step(1);
        end
    endtask

    initial begin
        int w, n, highs;
        step(3);
        cur_req = "R1";
        check(pdrv === 1'b0, "R1 pdrv in reset", int'(pdrv), 0);
        check(first_pulse === 1'b0, "R1 first_pulse in reset", int'(first_pulse), 0);
        rst_n = 1'b1;
        ctrl = 8'd50;
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            hi = i[0]; lo = ~i[0];
            step(1);
            if (pdrv) highs++;
        end
        check(highs == 0, "R1 no drive while disabled", highs, 0);

        // R2: trigger level without a prior arm.
        cur_req = "R2";
        hi = 1'b0; lo = 1'b1; en = 1'b1;
        highs = 0;
        for (int i = 0; i < 6; i++) begin step(1); if (pdrv) highs++; end
        check(highs == 0, "R2 unarmed low indication", highs, 0);

        // R3 and R5: arm, trigger, measure width.
        cur_req = "R3";
        do_trigger();
        check(pdrv === 1'b1, "R3 drive one edge after trigger", int'(pdrv), 1);
        cur_req = "R5";
        measure_high(w);
        check(w == 30, "R5 pulse width ctrl-offset", w, 30);

        // R4: rise during on time does not arm; held low level gives no restart.
        cur_req = "R4";
        lo = 1'b0; step(2);
        do_trigger();
        hi = 1'b1; lo = 1'b0; step(1);
        hi = 1'b0; lo = 1'b1; step(1);
        measure_high(w);
        highs = 0;
        for (int i = 0; i < 12; i++) begin step(1); if (pdrv) highs++; end
        check(highs == 0, "R4 no restart after on-time arming attempt", highs, 0);
        lo = 1'b0;

        // R7: peak limit.
        cur_req = "R7";
        ctrl = 8'd200;
        do_trigger();
        measure_high(w);
        check(w == RMAX, "R7 width capped at ramp peak", w, RMAX);
        lo = 1'b0; step(2);

        // R8: overcurrent held from the start ends the pulse after blanking.
        cur_req = "R8";
        ocp = 1'b1;
        do_trigger();
        measure_high(w);
        check(w == BLK + 1, "R8 overcurrent after blanking", w, BLK + 1);
        ocp = 1'b0; lo = 1'b0; step(2);
        do_trigger();
        step(BLK + 3);
        ocp = 1'b1; step(1);
        check(pdrv === 1'b0, "R8 overcurrent ends pulse next edge", int'(pdrv), 0);
        ocp = 1'b0; lo = 1'b0; step(2);

        // R6: control word at offset gives zero duty, even past the restart time.
        cur_req = "R6";
        ctrl = 8'(OFF);
        highs = 0;
        for (int i = 0; i < 400; i++) begin
            hi = (i % 10 == 0); lo = (i % 10 == 5);
            step(1);
            if (pdrv) highs++;
        end
        check(highs == 0, "R6 zero duty at offset", highs, 0);
        hi = 1'b0; lo = 1'b0;

        // R9: restart period without detector events.
        cur_req = "R9";
        ctrl = 8'd40;
        n = 0;
        while (pdrv !== 1'b1 && n < 400) begin step(1); n++; end
        check(pdrv === 1'b1, "R9 timer restart occurred", int'(pdrv), 1);
        n = 0;
        step(1); n++;
        while (!(pdrv === 1'b1 && n > 25) && n < 400) begin step(1); n++; end
        check(n == WD, "R9 restart period", n, WD);

        // R10: overvoltage blocks and aborts.
        cur_req = "R10";
        ovp = 1'b1;
        highs = 0;
        for (int i = 0; i < 300; i++) begin step(1); if (pdrv) highs++; end
        check(highs == 0, "R10 no pulse during overvoltage", highs, 0);
        ovp = 1'b0; step(1);
        check(pdrv === 1'b1, "R10 pending restart after clear", int'(pdrv), 1);
        measure_high(w);
        ctrl = 8'd200;
        do_trigger();
        step(3);
        ovp = 1'b1; step(1);
        check(pdrv === 1'b0, "R10 overvoltage aborts pulse", int'(pdrv), 0);
        ovp = 1'b0; lo = 1'b0; step(2);

        // R11 and R12: sticky flag, disable abort, arming discarded.
        cur_req = "R11";
        check(first_pulse === 1'b1, "R11 flag held while enabled", int'(first_pulse), 1);
        cur_req = "R12";
        do_trigger();
        step(2);
        en = 1'b0; step(1);
        check(pdrv === 1'b0, "R12 disable ends pulse", int'(pdrv), 0);
        check(first_pulse === 1'b0, "R11 flag cleared by disable", int'(first_pulse), 0);
        lo = 1'b0; hi = 1'b1; step(1);
        en = 1'b1; hi = 1'b0; step(1);
        lo = 1'b1;
        highs = 0;
        for (int i = 0; i < 6; i++) begin step(1); if (pdrv) highs++; end
        check(highs == 0, "R12 arming discarded on disable", highs, 0);
        check(first_pulse === 1'b0, "R11 flag low before first pulse", int'(first_pulse), 0);
        cur_req = "R11";
        do_trigger();
        check(pdrv === 1'b1 && first_pulse === 1'b1, "R11 flag rises with first pulse",
              int'(first_pulse), 1);
        lo = 1'b0;
        step(5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule